// File: doc/BRIEF.md
# Parallel ADC Sampling Sequencer

This block sits on the host side of a 12-bit parallel-output sampling converter that has a separate convert-start strobe, active-low chip select and read strobes, and an end-of-conversion status line that falls when a result is ready and rises again once that result has been read. The sequencer starts conversions at a programmable interval counted in system clock cycles. It waits for the status line to fall and then reads the result without starting a new conversion. The captured word is sent out on a valid/ready stream.

The converter's minimum start pulse, its data-access time and its track/hold acquisition time are given as nanosecond parameters, together with the system clock period. Each one is turned into a whole number of cycles, rounded up. The result is two's complement with a step of 10 V / 4096, and it is sign-extended to the stream width. Two sticky flags report faults: one for a result that was thrown away because the stream was stalled, and one for a conversion that never signalled completion.

Top module: `adc_host_ctrl`

## Requirements
- R1: Each conversion start holds `adc_convst_n` low for exactly ceil(T_STARTPW_NS / CLK_NS) consecutive cycles, with `adc_cs_n` and `adc_rd_n` high for the whole pulse.
- R2: A read begins only after the synchronized `adc_int_n` has been seen low. `adc_cs_n` and `adc_rd_n` then go low together, with `adc_convst_n` high, for exactly ceil(T_ACCESS_NS / CLK_NS) cycles. The word captured is the `adc_data` value present in the last of those cycles.
- R3: `adc_convst_n` does not fall until at least ceil(T_ACQ_NS / CLK_NS) cycles after the most recent fall of `adc_int_n`.
- R4: No conversion is started while the synchronized `adc_int_n` is low, so a start never happens before the previous result has been read and the status line has returned high.
- R5: While enabled, a start is issued on the first cycle in which at least `period` cycles have passed since the previous start and R3 and R4 allow it. When nothing else holds a start back, successive falling edges of `adc_convst_n` are exactly `period` cycles apart. The first start after enable or reset does not wait for `period`.
- R6: `m_data` is the 12-bit result with bit 11 copied into all upper bits, up to OUT_W bits. Once `m_valid` is high, `m_valid` and `m_data` hold until a cycle with `m_ready` high.
- R7: A result captured in a cycle where `m_valid` is high and `m_ready` is low is discarded. The held word is unchanged, and `overflow` goes high and stays high until reset.
- R8: If the synchronized `adc_int_n` is not low within `timeout_limit`+1 cycles after a start pulse ends, `timeout_err` goes high and stays high until reset. The controller returns to idle and goes on scheduling starts.
- R9: While `enable` is low, all three control outputs are high from the next cycle on, and no conversion is started.
- R10: After reset, all three control outputs are high, `m_valid` is low and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run sampling while high |
| period | input | PERIOD_W | Minimum cycles between conversion starts |
| timeout_limit | input | TMO_W | Cycles allowed for end-of-conversion after a start |
| adc_convst_n | output | 1 | Convert-start strobe, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_int_n | input | 1 | End-of-conversion status, low when a result is ready (asynchronous) |
| adc_data | input | RES_W | Converter data bus |
| m_valid | output | 1 | Result stream valid |
| m_ready | input | 1 | Result stream ready |
| m_data | output | OUT_W | Sign-extended result |
| overflow | output | 1 | Sticky: a result was dropped |
| timeout_err | output | 1 | Sticky: a conversion never completed |

## Verification
The assertions check the following on every cycle: start and read strobes never overlap, chip select and read move together, the strobes hold low for their full width, no start is issued while the status line is low or before the acquisition timer has run out, a stalled stream word stays stable, and both flags stay set once raised. The bench scenarios are the only place to show that the word captured is the one valid after the access wait. They also show that start spacing equals the programmed period when nothing else holds it back, that the real gap from the converter's status fall meets the acquisition time, and that the timeout recovers to normal sampling once the converter answers again. The bench model drives the data bus with a wrong value until the access time has passed, so a read that is too short shows up as a data mismatch.

// File: rtl/adc_host_pkg.sv
// Shared types and helpers for the parallel ADC sampling sequencer.
// Assumes all timing parameters are given in whole nanoseconds.
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_READ,
        ST_RELEASE
    } seq_state_t;

    // Whole cycles that cover a time in ns, never fewer than one.
    function automatic int cycles_for(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/adc_int_sync.sv
// Multi-stage synchronizer for the converter's asynchronous status line.
// Assumes the line idles high; the reset value is high so no false event is seen.
module adc_int_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the asynchronous line.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= async_n;
                end
            end else begin : g_next
                // Later stages settle the sampled value.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];

endmodule

// File: rtl/adc_span_timer.sv
// Saturating cycle counter that reports when a span of at least `limit` cycles
// has passed since `restart`. It resets to full scale, so a span counts as
// already elapsed at start-up. `saturate` forces full scale.
module adc_span_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         saturate,
    input  logic [W-1:0] limit,
    output logic         reached
);

    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] count;

    // Counts cycles since the last restart and stops at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= FULL;
        else if (restart)          count <= W'(1);
        else if (saturate)         count <= FULL;
        else if (count != FULL)    count <= count + W'(1);
    end

    assign reached = (count >= limit);

endmodule

// File: rtl/adc_seq_fsm.sv
// Conversion and read sequencer. It issues a start pulse, waits for the
// synchronized end-of-conversion, performs a read of fixed length and waits for
// the status line to return high. It assumes `int_low` is already synchronized.
// The strobe outputs are registered from the next state, so they do not glitch.
module adc_seq_fsm
    import adc_host_pkg::*;
#(
    parameter int START_CYC = 3,
    parameter int ACC_CYC   = 10,
    parameter int TMO_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             period_done,
    input  logic             gap_done,
    input  logic             int_low,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             cnv_n,
    output logic             cs_n,
    output logic             rd_n,
    output logic             start_issue,
    output logic             capture,
    output logic             int_seen,
    output logic             tmo_fire
);

    localparam int MAXC  = (START_CYC > ACC_CYC) ? START_CYC : ACC_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LAST   = CNT_W'(ACC_CYC - 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [TMO_W-1:0] tcnt, tcnt_nxt;
    logic             cnv_q, cs_q, rd_q;

    assign start_issue = (state == ST_IDLE) && enable && period_done && gap_done && !int_low;
    assign capture     = (state == ST_READ) && (cnt == ACC_LAST);
    assign int_seen    = (state == ST_WAIT) && int_low;
    assign tmo_fire    = (state == ST_WAIT) && !int_low && (tcnt >= tmo_limit);

    // Next-state and counter logic for one sample.
    always_comb begin
        nxt      = state;
        cnt_nxt  = cnt;
        tcnt_nxt = tcnt;
        if (!enable) begin
            nxt      = ST_IDLE;
            cnt_nxt  = '0;
            tcnt_nxt = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_issue) begin
                        nxt     = ST_START;
                        cnt_nxt = '0;
                    end
                end
                ST_START: begin
                    if (cnt == START_LAST) begin
                        nxt      = ST_WAIT;
                        tcnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (int_low) begin
                        nxt     = ST_READ;
                        cnt_nxt = '0;
                    end else if (tmo_fire) begin
                        nxt = ST_IDLE;
                    end else begin
                        tcnt_nxt = tcnt + TMO_W'(1);
                    end
                end
                ST_READ: begin
                    if (cnt == ACC_LAST) nxt = ST_RELEASE;
                    else                 cnt_nxt = cnt + CNT_W'(1);
                end
                ST_RELEASE: begin
                    if (!int_low) nxt = ST_IDLE;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State, counters and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            tcnt  <= '0;
            cnv_q <= 1'b1;
            cs_q  <= 1'b1;
            rd_q  <= 1'b1;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            tcnt  <= tcnt_nxt;
            cnv_q <= (nxt != ST_START);
            cs_q  <= (nxt != ST_READ);
            rd_q  <= (nxt != ST_READ);
        end
    end

    assign cnv_n = cnv_q;
    assign cs_n  = cs_q;
    assign rd_n  = rd_q;

    AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_START && cnt != START_LAST && enable) |=> !cnv_n); // R1
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_READ && cnt != ACC_LAST && enable) |=> !rd_n); // R2
    AST_READ_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_n) |-> $past(int_low)); // R2
    AST_ARMED_START: assert property (@(posedge clk) disable iff (!rst_n) $fell(cnv_n) |-> $past(!int_low)); // R4

endmodule

// File: rtl/adc_out_stage.sv
// Single-slot result register on a valid/ready stream. It sign-extends the
// converter word. A capture that arrives while the slot is held and not
// accepted is dropped, and a sticky overflow flag records it.
module adc_out_stage #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [IN_W-1:0]  din,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [OUT_W-1:0] m_data,
    output logic             overflow
);

    logic [OUT_W-1:0] wide;
    logic             valid_q, ovf_q;
    logic [OUT_W-1:0] data_q;

    generate
        if (OUT_W > IN_W) begin : g_ext
            assign wide = {{(OUT_W - IN_W){din[IN_W-1]}}, din};
        end else begin : g_same
            assign wide = din[OUT_W-1:0];
        end
    endgenerate

    // Loads, drains or drops results and tracks the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            ovf_q   <= 1'b0;
        end else if (capture) begin
            if (valid_q && !m_ready) begin
                ovf_q <= 1'b1;
            end else begin
                valid_q <= 1'b1;
                data_q  <= wide;
            end
        end else if (valid_q && m_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign m_valid  = valid_q;
    assign m_data   = data_q;
    assign overflow = ovf_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R7
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (capture && m_valid && !m_ready) |=> overflow); // R7

endmodule

// File: rtl/adc_host_ctrl.sv
// Host-side sampling controller for a parallel 12-bit converter run with
// separate start and read strobes. It turns the nanosecond timing limits into
// cycle counts (rounded up), paces starts by `period`, enforces the acquisition
// gap and streams sign-extended results. It assumes `adc_data` holds its value
// while the read strobes are low.
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int T_STARTPW_NS = 30,
    parameter int T_ACCESS_NS = 100,
    parameter int T_ACQ_NS    = 350,
    parameter int RES_W       = 12,
    parameter int OUT_W       = 16,
    parameter int PERIOD_W    = 16,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic [TMO_W-1:0]    timeout_limit,
    output logic                adc_convst_n,
    output logic                adc_cs_n,
    output logic                adc_rd_n,
    input  logic                adc_int_n,
    input  logic [RES_W-1:0]    adc_data,
    output logic                m_valid,
    input  logic                m_ready,
    output logic [OUT_W-1:0]    m_data,
    output logic                overflow,
    output logic                timeout_err
);

    localparam int START_CYC = cycles_for(T_STARTPW_NS, CLK_NS);
    localparam int ACC_CYC   = cycles_for(T_ACCESS_NS, CLK_NS);
    localparam int ACQ_CYC   = cycles_for(T_ACQ_NS, CLK_NS);
    localparam int GAP_W     = $clog2(ACQ_CYC + 1) + 1;

    logic int_sync_n;
    logic period_done, gap_done;
    logic start_issue, capture, int_seen, tmo_fire;
    logic err_q;

    adc_int_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (adc_int_n),
        .sync_n  (int_sync_n)
    );

    adc_span_timer #(.W(PERIOD_W)) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (start_issue),
        .saturate (!enable),
        .limit    (period),
        .reached  (period_done)
    );

    adc_span_timer #(.W(GAP_W)) u_acq (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (int_seen || tmo_fire),
        .saturate (1'b0),
        .limit    (GAP_W'(ACQ_CYC)),
        .reached  (gap_done)
    );

    adc_seq_fsm #(
        .START_CYC (START_CYC),
        .ACC_CYC   (ACC_CYC),
        .TMO_W     (TMO_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .period_done (period_done),
        .gap_done    (gap_done),
        .int_low     (!int_sync_n),
        .tmo_limit   (timeout_limit),
        .cnv_n       (adc_convst_n),
        .cs_n        (adc_cs_n),
        .rd_n        (adc_rd_n),
        .start_issue (start_issue),
        .capture     (capture),
        .int_seen    (int_seen),
        .tmo_fire    (tmo_fire)
    );

    adc_out_stage #(.IN_W(RES_W), .OUT_W(OUT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .din      (adc_data),
        .m_ready  (m_ready),
        .m_valid  (m_valid),
        .m_data   (m_data),
        .overflow (overflow)
    );

    // Sticky record of a conversion that never signalled completion.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (tmo_fire) err_q <= 1'b1;
    end

    assign timeout_err = err_q;

    AST_CONV_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !adc_convst_n |-> (adc_cs_n && adc_rd_n)); // R1
    AST_CS_RD_PAIR: assert property (@(posedge clk) disable iff (!rst_n) adc_cs_n == adc_rd_n); // R2
    AST_START_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(adc_convst_n) |-> gap_done); // R3
    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !$past(enable) |-> (adc_convst_n && adc_cs_n && adc_rd_n)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) timeout_err |=> timeout_err); // R8

endmodule

// File: tb/adc_host_ctrl_test.sv
// Bench for adc_host_ctrl: a behavioural converter model, a random-ready
// consumer and directed phases, all checked against values computed here.
module adc_host_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int START_EXP  = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int ACC_EXP    = (100 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int ACQ_EXP    = (350 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int CONV_CYC   = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [15:0] period;
    logic [15:0] timeout_limit;
    logic        cnv_n, cs_n, rd_n;
    logic        int_n_r;
    logic [11:0] adc_data;
    logic        m_valid, m_ready;
    logic [15:0] m_data;
    logic        overflow, timeout_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // converter model state
    bit          busy = 0, mute = 0, cnv_prev = 1;
    int          conv_left = 0, rdcnt = 0, cnv_low_len = 0;
    int          negcnt = 0, last_int_fall = -1, last_start = 0;
    int          start_cnt = 0, captures = 0, sample_idx = 0;
    bit          exact_mode = 0, prev_start_valid = 0;
    int          exact_period = 0;
    int          ready_mode = 1;
    logic [11:0] result = 12'h000;
    logic [15:0] q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign adc_data = (rdcnt >= ACC_EXP && !rd_n && !cs_n) ? result : ~result;

    adc_host_ctrl #(.CLK_NS(CLK_PERIOD)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .period        (period),
        .timeout_limit (timeout_limit),
        .adc_convst_n  (cnv_n),
        .adc_cs_n      (cs_n),
        .adc_rd_n      (rd_n),
        .adc_int_n     (int_n_r),
        .adc_data      (adc_data),
        .m_valid       (m_valid),
        .m_ready       (m_ready),
        .m_data        (m_data),
        .overflow      (overflow),
        .timeout_err   (timeout_err)
    );

    function automatic logic [15:0] sext(input logic [11:0] v);
        return {{4{v[11]}}, v};
    endfunction

    function automatic logic [11:0] next_sample(input int idx);
        case (idx)
            0: return 12'h800;
            1: return 12'h7FF;
            2: return 12'h000;
            3: return 12'hFFF;
            4: return 12'h001;
            default: return 12'($urandom);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_captures(input int n);
        int target;
        target = captures + n;
        while (captures < target) step();
    endtask

    // One negative-edge step of the converter model and the consumer.
    task automatic model_tick();
        negcnt++;
        if (ready_mode == 0)      m_ready = 1'b0;
        else if (ready_mode == 1) m_ready = 1'b1;
        else                      m_ready = ($urandom % 100) < 70;
        // consumer: R6 ordering, value and sign extension
        if (m_valid && m_ready) begin
            if (q.size() == 0) check(0, "R6 unexpected word", m_data, 0);
            else begin
                check(m_data == q[0], "R6 stream word", m_data, q[0]);
                void'(q.pop_front());
            end
        end
        // conversion progress
        if (busy) begin
            conv_left--;
            if (conv_left == 0) begin
                busy = 0;
                result = next_sample(sample_idx);
                sample_idx++;
                int_n_r = 1'b0;
                last_int_fall = negcnt;
            end
        end
        // start strobe
        if (!cnv_n) begin
            cnv_low_len++;
            check(cs_n && rd_n, "R1 strobes overlap", {cs_n, rd_n}, 2'b11);
            if (cnv_prev) begin
                check(!busy && int_n_r, "R4 start while result pending", {busy, int_n_r}, 2'b01);
                if (last_int_fall >= 0)
                    check(negcnt - last_int_fall >= ACQ_EXP, "R3 acquisition gap", negcnt - last_int_fall, ACQ_EXP);
                if (exact_mode && prev_start_valid)
                    check(negcnt - last_start == exact_period, "R5 start spacing", negcnt - last_start, exact_period);
                last_start = negcnt;
                prev_start_valid = 1;
                start_cnt++;
                if (!mute) begin
                    busy = 1;
                    conv_left = CONV_CYC;
                end
            end
        end else if (!cnv_prev) begin
            check(cnv_low_len == START_EXP, "R1 start pulse width", cnv_low_len, START_EXP);
            cnv_low_len = 0;
        end
        // read strobes
        if (!rd_n && !cs_n) begin
            if (rdcnt == 0) check(int_n_r == 1'b0, "R2 read before end of conversion", int_n_r, 0);
            int_n_r = 1'b1;
            rdcnt++;
            if (rdcnt == ACC_EXP) begin
                if (m_valid && !m_ready) begin
                    // R7: dropped, nothing queued
                end else begin
                    q.push_back(sext(result));
                end
                captures++;
            end
        end else begin
            if (rdcnt != 0) check(rdcnt == ACC_EXP, "R2 read length", rdcnt, ACC_EXP);
            rdcnt = 0;
        end
        cnv_prev = cnv_n;
    endtask

    task automatic run_model();
        forever begin
            @(negedge clk);
            model_tick();
        end
    endtask

    task automatic run_watchdog();
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", captures, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int starts_before, caps_before;
        bit bad;
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        enable = 1'b0;
        period = 16'd120;
        timeout_limit = 16'd60;
        int_n_r = 1'b1;
        m_ready = 1'b1;
        fork
            run_model();
            run_watchdog();
        join_none

        // R10: reset state
        repeat (4) step();
        check(cnv_n && cs_n && rd_n, "R10 strobes in reset", {cnv_n, cs_n, rd_n}, 3'b111);
        rst_n = 1'b1;
        step();
        check(cnv_n && cs_n && rd_n, "R10 strobes after reset", {cnv_n, cs_n, rd_n}, 3'b111);
        check(!m_valid && !overflow && !timeout_err, "R10 stream and flags", {m_valid, overflow, timeout_err}, 0);

        // Phase A: fixed period, exact spacing, corner data values (R5, R6)
        exact_period = 120;
        exact_mode = 1;
        prev_start_valid = 0;
        enable = 1'b1;
        wait_captures(8);
        exact_mode = 0;

        // Phase C: stalled stream, drops and hold (R6, R7)
        repeat (5) step();
        check(q.size() == 0, "R6 drained before stall", q.size(), 0);
        check(overflow == 1'b0, "R7 no drop yet", overflow, 0);
        ready_mode = 0;
        wait_captures(4);
        step();
        check(m_valid == 1'b1, "R6 valid held", m_valid, 1);
        check(q.size() == 1, "R7 later results dropped", q.size(), 1);
        if (q.size() > 0) check(m_data == q[0], "R7 held word unchanged", m_data, q[0]);
        check(overflow == 1'b1, "R7 overflow set", overflow, 1);
        ready_mode = 1;
        repeat (3) step();
        check(q.size() == 0 && !m_valid, "R6 held word delivered", q.size(), 0);
        check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);

        // Phase D: disable (R9)
        wait_captures(1);
        enable = 1'b0;
        starts_before = start_cnt;
        bad = 0;
        for (int i = 0; i < 80; i++) begin
            step();
            if (!(cnv_n && cs_n && rd_n)) bad = 1;
        end
        check(!bad, "R9 strobes high while disabled", bad, 0);
        check(start_cnt == starts_before, "R9 no start while disabled", start_cnt, starts_before);
        prev_start_valid = 0;
        enable = 1'b1;

        // Phase E: silent converter (R8)
        wait_captures(1);
        check(timeout_err == 1'b0, "R8 no timeout yet", timeout_err, 0);
        mute = 1;
        starts_before = start_cnt;
        caps_before = captures;
        repeat (450) step();
        check(timeout_err == 1'b1, "R8 timeout flagged", timeout_err, 1);
        check(start_cnt - starts_before >= 2, "R8 returns to idle and retries", start_cnt - starts_before, 2);
        check(captures == caps_before, "R8 no read without end of conversion", captures - caps_before, 0);
        mute = 0;
        wait_captures(3);
        check(timeout_err == 1'b1, "R8 timeout sticky", timeout_err, 1);

        // Phase B: random periods and random ready
        ready_mode = 2;
        for (int i = 0; i < 6; i++) begin
            period = 16'($urandom_range(0, 90));
            repeat (500) step();
        end

        // Drain and finish
        ready_mode = 1;
        wait_captures(1);
        enable = 1'b0;
        repeat (60) step();
        check(q.size() == 0 && !m_valid, "R6 all results delivered", q.size(), 0);
        check(sample_idx > 20, "R5 sampling progressed", sample_idx, 20);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule